// File: doc/BRIEF.md
# Eight-Way Condition Compare Unit

This block compares two unsigned operands and reduces the outcome to one condition flag. A 3-bit selector picks the relation to test. Six codes pick an ordering or equality relation between the operands. The other two codes force the flag high or low whatever the operands hold. The result is captured in a register that later conditional-branch logic reads: a branch is taken only when the captured flag is high.

The flag updates only on a clock edge where the compare strobe is high. Between compares it keeps its last value, so the branch logic may read it at any later cycle. The magnitude test is built from fixed-width slices that are combined from the most significant slice downward, which keeps logic depth flat as the operand width grows.

Top module: `cond_cmp_unit`

## Requirements
- R1: A synchronous active-high reset clears the flag to 0. The flag reads 0 on the first falling edge after a reset edge.
- R2: Selector code 0 (3'b000) sets the flag when A is greater than B.
- R3: Code 1 (3'b001) sets the flag when A equals B. Code 2 (3'b010) sets it when A is less than B.
- R4: Code 3 (3'b011) tests A less than or equal to B. Code 4 (3'b100) tests A not equal to B. Code 5 (3'b101) tests A greater than or equal to B.
- R5: Code 6 (3'b110) always loads 1 and code 7 (3'b111) always loads 0, whatever the operand values.
- R6: While the compare strobe is low, the flag holds its value and ignores any change on the operands or the selector.
- R7: A compare issued with the strobe high at a rising edge is visible on the flag output right after that edge, a latency of one cycle.
- R8: Operands are compared as unsigned values, so an operand with its top bit set is greater than any operand with the top bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_en | input | 1 | Compare strobe; the flag loads on edges where this is high |
| opnd_a | input | DATA_W (32) | Left operand A |
| opnd_b | input | DATA_W (32) | Right operand B |
| cond_sel | input | 3 | Condition selector, codes 0 to 7 |
| flag_q | output | 1 | Registered condition flag |

## Verification
Each result is due one rising edge after the edge that samples a high strobe. A hold or a reset likewise shows on the flag right after its edge. The bench drives inputs on the falling edge and keeps a behavioural reference flag that it updates once per rising edge. On the next falling edge it compares the output with that reference, so every check looks at the cycle where the register has just settled. Hold checks change the operands and the selector with the strobe low and compare the flag at that same point.

// File: rtl/cond_cmp_pkg.sv
package cond_cmp_pkg;

  typedef enum logic [2:0] {
    COND_GT    = 3'd0,
    COND_EQ    = 3'd1,
    COND_LT    = 3'd2,
    COND_LE    = 3'd3,
    COND_NE    = 3'd4,
    COND_GE    = 3'd5,
    COND_TRUE  = 3'd6,
    COND_FALSE = 3'd7
  } cond_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

endpackage

// File: rtl/cond_cmp_slice.sv
module cond_cmp_slice #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a_sl,
  input  logic [SLICE_W-1:0] b_sl,
  output logic               sl_gt,
  output logic               sl_eq
);
  always_comb begin
    sl_gt = (a_sl > b_sl);
    sl_eq = (a_sl == b_sl);
  end
endmodule

// File: rtl/cond_cmp_mag.sv
module cond_cmp_mag
  import cond_cmp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output rel_t              rel
);
  localparam int NSLICE = (DATA_W + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W  = NSLICE * SLICE_W;

  logic [PAD_W-1:0]  a_pad;
  logic [PAD_W-1:0]  b_pad;
  logic [NSLICE-1:0] s_gt;
  logic [NSLICE-1:0] s_eq;

  assign a_pad = PAD_W'(a_in);
  assign b_pad = PAD_W'(b_in);

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    cond_cmp_slice #(.SLICE_W(SLICE_W)) slice_i (
      .a_sl  (a_pad[g*SLICE_W +: SLICE_W]),
      .b_sl  (b_pad[g*SLICE_W +: SLICE_W]),
      .sl_gt (s_gt[g]),
      .sl_eq (s_eq[g])
    );
  end

  always_comb begin
    logic gt_acc;
    logic eq_acc;
    gt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = NSLICE - 1; i >= 0; i--) begin
      gt_acc = gt_acc | (eq_acc & s_gt[i]);
      eq_acc = eq_acc & s_eq[i];
    end
    rel.gt = gt_acc;
    rel.eq = eq_acc;
    rel.lt = ~gt_acc & ~eq_acc;
  end
endmodule

// File: rtl/cond_cmp_select.sv
module cond_cmp_select
  import cond_cmp_pkg::*;
(
  input  rel_t       rel,
  input  logic [2:0] sel,
  output logic       hit
);
  always_comb begin
    unique case (cond_e'(sel))
      COND_GT:    hit = rel.gt;
      COND_EQ:    hit = rel.eq;
      COND_LT:    hit = rel.lt;
      COND_LE:    hit = rel.lt | rel.eq;
      COND_NE:    hit = ~rel.eq;
      COND_GE:    hit = rel.gt | rel.eq;
      COND_TRUE:  hit = 1'b1;
      COND_FALSE: hit = 1'b0;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_cmp_flag.sv
module cond_cmp_flag (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cond_cmp_unit.sv
module cond_cmp_unit
  import cond_cmp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [2:0]        cond_sel,
  output logic              flag_q
);
  rel_t rel_w;
  logic hit_w;

  cond_cmp_mag #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) mag_i (
    .a_in (opnd_a),
    .b_in (opnd_b),
    .rel  (rel_w)
  );

  cond_cmp_select sel_i (
    .rel (rel_w),
    .sel (cond_sel),
    .hit (hit_w)
  );

  cond_cmp_flag flag_i (
    .clk  (clk),
    .rst  (rst),
    .load (cmp_en),
    .d    (hit_w),
    .q    (flag_q)
  );
endmodule

// File: rtl/cond_cmp_unit_chk.sv
module cond_cmp_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_en,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [2:0]        cond_sel,
  input logic              flag_q
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> $stable(flag_q));

  assert_gt_R2: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cond_sel == 3'd0) |=> (flag_q == ($past(opnd_a) > $past(opnd_b))));

  assert_eq_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cond_sel == 3'd1) |=> (flag_q == ($past(opnd_a) == $past(opnd_b))));

  assert_ne_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cond_sel == 3'd4) |=> (flag_q == ($past(opnd_a) != $past(opnd_b))));

  assert_true_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cond_sel == 3'd6) |=> flag_q);

  assert_false_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cond_sel == 3'd7) |=> !flag_q);
endmodule

bind cond_cmp_unit cond_cmp_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmp_en   (cmp_en),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .cond_sel (cond_sel),
  .flag_q   (flag_q)
);

// File: tb/cond_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module cond_cmp_unit_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_en = 1'b0;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic [2:0]    cond_sel = 3'd0;
  logic          flag_q;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  ref_flag = 1'b0;

  always #2.5 clk = ~clk;

  cond_cmp_unit #(.DATA_W(DW)) dut_i (
    .clk (clk), .rst (rst), .cmp_en (cmp_en),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .cond_sel (cond_sel),
    .flag_q (flag_q)
  );

  function automatic bit expect_of(int unsigned s, longint unsigned a, longint unsigned b);
    case (s)
      0: return a > b;
      1: return a == b;
      2: return a < b;
      3: return a <= b;
      4: return a != b;
      5: return a >= b;
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reference model: behaviour at each rising edge
  always @(posedge clk) begin
    if (rst)         ref_flag <= 1'b0;
    else if (cmp_en) ref_flag <= expect_of(cond_sel, opnd_a, opnd_b);
  end

  task automatic check(string req);
    n_checks++;
    if (flag_q !== ref_flag) begin
      n_fail++;
      $display("FAIL %s: flag_q=%b expected=%b (a=%h b=%h sel=%0d)",
               req, flag_q, ref_flag, opnd_a, opnd_b, cond_sel);
    end
  endtask

  // drive on falling edge, check on next falling edge (one rising edge later)
  task automatic step(bit en, logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] s, string req);
    cmp_en = en; opnd_a = a; opnd_b = b; cond_sel = s;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset");

    // R2 greater-than
    step(1, 32'd10, 32'd3, 3'd0, "R2 gt true");
    step(1, 32'd3, 32'd10, 3'd0, "R2 gt false");
    step(1, 32'd7, 32'd7, 3'd0, "R2 gt equal");
    // R3 equal / less
    step(1, 32'hDEADBEEF, 32'hDEADBEEF, 3'd1, "R3 eq true");
    step(1, 32'hDEADBEEF, 32'hDEADBEEE, 3'd1, "R3 eq false");
    step(1, 32'd1, 32'd2, 3'd2, "R3 lt true");
    step(1, 32'd2, 32'd2, 3'd2, "R3 lt equal");
    // R4 le / ne / ge
    step(1, 32'd5, 32'd5, 3'd3, "R4 le equal");
    step(1, 32'd6, 32'd5, 3'd3, "R4 le greater");
    step(1, 32'd5, 32'd5, 3'd4, "R4 ne equal");
    step(1, 32'h100, 32'h1, 3'd4, "R4 ne differ");
    step(1, 32'd5, 32'd5, 3'd5, "R4 ge equal");
    step(1, 32'd4, 32'd5, 3'd5, "R4 ge less");
    // R5 constants
    step(1, 32'd0, 32'hFFFFFFFF, 3'd6, "R5 true");
    step(1, 32'd9, 32'd9, 3'd7, "R5 false");
    step(1, 32'd9, 32'd9, 3'd6, "R5 true again");
    // R6 hold while strobe low
    step(0, 32'd0, 32'd9, 3'd7, "R6 hold high");
    step(0, 32'd1, 32'd1, 3'd0, "R6 hold high 2");
    step(1, 32'd1, 32'd1, 3'd7, "R6 load low");
    step(0, 32'd1, 32'd1, 3'd6, "R6 hold low");
    // R8 unsigned ordering
    step(1, 32'h80000000, 32'd1, 3'd0, "R8 msb greater");
    step(1, 32'hFFFFFFFF, 32'h7FFFFFFF, 3'd2, "R8 msb not less");
    step(1, 32'h7FFFFFFF, 32'h80000000, 3'd2, "R8 msb less");
    // R7 back-to-back compares, one-cycle latency
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] ra;
      logic [DW-1:0] rb;
      ra = $urandom;
      rb = ($urandom_range(0, 3) == 0) ? ra : DW'($urandom);
      step(bit'($urandom_range(0, 3) != 0), ra, rb, 3'($urandom_range(0, 7)), "R7 stream");
    end
    // R1 reset in mid run after flag set
    step(1, 32'd0, 32'd0, 3'd6, "R1 pre-reset set");
    rst = 1'b1; cmp_en = 1'b1; cond_sel = 3'd6;
    @(negedge clk);
    check("R1 mid reset");
    rst = 1'b0; cmp_en = 1'b0;
    @(negedge clk);
    check("R1 mid reset hold");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule